// File: doc/BRIEF.md
# First-Order Sigma-Delta Modulator Loop

This block is a cycle-exact digital model of a first-order sigma-delta modulator. Each cycle where the sample enable is high, the block takes one signed fixed-point input sample. It subtracts the feedback value held from the previous sample and adds the result to an integrator register. It then reduces the integrator to a single bit with a comparator. That bit selects a feedback level of positive or negative full scale, which is used in the next sample's subtraction.

The bit stream is the main output. The feedback level, the difference term and the integrator value are also brought out, so the loop can be traced one sample at a time against a reference sequence. After reset the feedback term is zero, not a full-scale level. This matters because the first sample then sees the input unchanged, and the whole trace that follows depends on it.

The input is a two's-complement fraction with `FRAC_W` fraction bits. Full scale is `2**FRAC_W` counts, and callers keep the input between negative and positive full scale.

Top module: `sdm_first_order`

## Requirements
- R1: While reset is high, and afterwards until the first enabled sample, `diff_o`, `integ_o`, `bit_o` and `fb_o` are all zero.
- R2: On an enabled sample, `diff_o` becomes the input minus the `fb_o` value held before that sample (zero for the first sample after reset).
- R3: On an enabled sample, `integ_o` becomes its previous value plus the new `diff_o`, with no leakage or scaling.
- R4: `bit_o` is 1 exactly when the new integrator value is strictly greater than zero; an integrator value of exactly zero gives 0.
- R5: After the first enabled sample, `fb_o` is +full scale (`2**FRAC_W`) when `bit_o` is 1 and −full scale when `bit_o` is 0.
- R6: On a cycle with `sample_en` low, none of the four outputs changes, whatever the input does.
- R7: With a constant input of +3/8 (3 counts, `FRAC_W`=3) from reset, samples 1 to 5 give integrator values 3, −2, 9, 4, −1 counts and bits 1, 0, 1, 1, 0.
- R8: With a constant input of +3/8 from reset, sample 17 repeats the integrator value of sample 1, and the sum of `fb_o` over samples 1 to 16 is 16 × 3 counts, so the average equals the input.
- R9: For any constant input X from reset, the sum of `fb_o` over samples 1 to N equals (N+1)·X minus the integrator value at sample N+1.
- R10: For inputs within ±full scale, the integrator stays inside ±2 full scale and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Accept one input sample this cycle |
| sample_i | input | FRAC_W+2 | Signed fractional input sample |
| diff_o | output | FRAC_W+4 | Difference term of the latest sample (debug) |
| integ_o | output | FRAC_W+4 | Integrator value of the latest sample (debug) |
| bit_o | output | 1 | Quantized one-bit output |
| fb_o | output | FRAC_W+2 | Feedback level: zero after reset, then ±full scale |

## Verification
A constant +3/8 input run from reset is compared against the known integrator and bit sequence. This run tells apart a design that feeds back a full-scale level on the first sample, or one that uses greater-or-equal at the comparator, because sample 8 lands on an integrator of exactly zero. Constant inputs at zero, at both full-scale ends and at random levels exercise the running-sum identity between the feedback and the integrator, and push the integrator to its bounds. Sample-by-sample random inputs with enable gaps catch errors in the difference, accumulation and hold paths against a bench reference model.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    // Which feedback level the loop holds
    typedef enum logic [1:0] {
        FB_ZERO = 2'b00,
        FB_POS  = 2'b01,
        FB_NEG  = 2'b10
    } fb_sel_e;

    // Full-scale count for a given number of fraction bits
    function automatic int full_scale(input int frac_w);
        return 1 << frac_w;
    endfunction

    // Input word width: sign bit + one integer bit + fraction
    function automatic int in_width(input int frac_w);
        return frac_w + 2;
    endfunction

    // Integrator width: two extra integer bits of headroom
    function automatic int acc_width(input int frac_w);
        return frac_w + 4;
    endfunction

endpackage

// File: rtl/sdm_diff_node.sv
module sdm_diff_node #(
    parameter int IN_W  = 5,
    parameter int ACC_W = 7
) (
    input  logic signed [IN_W-1:0]  x_i,
    input  logic signed [IN_W-1:0]  w_i,
    output logic signed [ACC_W-1:0] b_o
);
    localparam int EXT_W = ACC_W - IN_W;

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] w_ext;

    always_comb begin
        x_ext = {{EXT_W{x_i[IN_W-1]}}, x_i};
        w_ext = {{EXT_W{w_i[IN_W-1]}}, w_i};
        b_o   = x_ext - w_ext;
    end
endmodule

// File: rtl/sdm_integrator.sv
module sdm_integrator #(
    parameter int ACC_W = 7,
    parameter int FS    = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] b_i,
    output logic signed [ACC_W-1:0] c_nxt_o,
    output logic signed [ACC_W-1:0] c_q_o
);
    typedef logic signed [ACC_W-1:0] acc_t;
    localparam acc_t LIM = acc_t'(2 * FS);

    logic signed [ACC_W-1:0] c_q;

    always_comb c_nxt_o = c_q + b_i;

    always_ff @(posedge clk) begin
        if (rst)     c_q <= '0;
        else if (en) c_q <= c_nxt_o;
    end

    assign c_q_o = c_q;

    // R3: accumulation step without leakage
    assert_accumulate_R3: assert property (@(posedge clk) disable iff (rst)
        en |=> (c_q == acc_t'($past(c_q) + $past(b_i))));

    // R10: integrator stays within twice full scale
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (c_q <= LIM) && (c_q >= -LIM));

    // R6: held when the enable is low
    assert_hold_integ_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(c_q));
endmodule

// File: rtl/sdm_quantizer.sv
module sdm_quantizer
    import sdm_pkg::*;
#(
    parameter int IN_W  = 5,
    parameter int ACC_W = 7,
    parameter int FS    = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] c_nxt_i,
    output logic                    d_o,
    output logic signed [IN_W-1:0]  w_o
);
    typedef logic signed [IN_W-1:0]  in_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    localparam in_t FB_HI = in_t'(FS);
    localparam in_t FB_LO = in_t'(-FS);

    fb_sel_e sel_q;
    fb_sel_e sel_nxt;

    always_comb sel_nxt = (c_nxt_i > acc_t'(0)) ? FB_POS : FB_NEG;

    always_ff @(posedge clk) begin
        if (rst)     sel_q <= FB_ZERO;
        else if (en) sel_q <= sel_nxt;
    end

    always_comb begin
        d_o = (sel_q == FB_POS);
        unique case (sel_q)
            FB_POS:  w_o = FB_HI;
            FB_NEG:  w_o = FB_LO;
            default: w_o = '0;
        endcase
    end

    // R4: strict threshold, zero maps to the low bit
    assert_threshold_R4: assert property (@(posedge clk) disable iff (rst)
        en |=> (d_o == ($past(c_nxt_i) > acc_t'(0))));

    // R5: feedback is a full-scale level once a sample was taken
    assert_feedback_level_R5: assert property (@(posedge clk) disable iff (rst)
        en |=> (w_o == (d_o ? FB_HI : FB_LO)));
endmodule

// File: rtl/sdm_first_order.sv
module sdm_first_order
    import sdm_pkg::*;
#(
    parameter int FRAC_W = 3,
    localparam int IN_W  = in_width(FRAC_W),
    localparam int ACC_W = acc_width(FRAC_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_en,
    input  logic signed [IN_W-1:0]  sample_i,
    output logic signed [ACC_W-1:0] diff_o,
    output logic signed [ACC_W-1:0] integ_o,
    output logic                    bit_o,
    output logic signed [IN_W-1:0]  fb_o
);
    localparam int FS = full_scale(FRAC_W);
    typedef logic signed [IN_W-1:0]  in_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    logic signed [ACC_W-1:0] b_nxt;
    logic signed [ACC_W-1:0] b_q;
    logic signed [ACC_W-1:0] c_nxt;

    sdm_diff_node #(.IN_W(IN_W), .ACC_W(ACC_W)) u_diff (
        .x_i (sample_i),
        .w_i (fb_o),
        .b_o (b_nxt)
    );

    sdm_integrator #(.ACC_W(ACC_W), .FS(FS)) u_integ (
        .clk     (clk),
        .rst     (rst),
        .en      (sample_en),
        .b_i     (b_nxt),
        .c_nxt_o (c_nxt),
        .c_q_o   (integ_o)
    );

    sdm_quantizer #(.IN_W(IN_W), .ACC_W(ACC_W), .FS(FS)) u_quant (
        .clk     (clk),
        .rst     (rst),
        .en      (sample_en),
        .c_nxt_i (c_nxt),
        .d_o     (bit_o),
        .w_o     (fb_o)
    );

    // Debug copy of the difference term
    always_ff @(posedge clk) begin
        if (rst)            b_q <= '0;
        else if (sample_en) b_q <= b_nxt;
    end

    assign diff_o = b_q;

    // R2: difference uses the feedback held before the sample
    assert_difference_R2: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> (diff_o == acc_t'($past(sample_i)) - acc_t'($past(fb_o))));

    // R6: all outputs hold without an enable
    assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> ($stable(diff_o) && $stable(bit_o) && $stable(fb_o)));

    // R10: input kept within full scale
    assert_input_range_R10: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> ((sample_i <= in_t'(FS)) && (sample_i >= in_t'(-FS))));
endmodule

// File: tb/test_sdm_first_order.sv
module test_sdm_first_order;
    localparam int CLK_PERIOD = 10;
    localparam int FRAC_W = 3;
    localparam int IN_W   = FRAC_W + 2;
    localparam int ACC_W  = FRAC_W + 4;
    localparam int FS     = 1 << FRAC_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_en = 1'b0;
    logic signed [IN_W-1:0]  sample_i = '0;
    logic signed [ACC_W-1:0] diff_o;
    logic signed [ACC_W-1:0] integ_o;
    logic                    bit_o;
    logic signed [IN_W-1:0]  fb_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model state (counts)
    int mb = 0, mc = 0, md = 0, mw = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdm_first_order #(.FRAC_W(FRAC_W)) i_sdm_first_order (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .sample_i  (sample_i),
        .diff_o    (diff_o),
        .integ_o   (integ_o),
        .bit_o     (bit_o),
        .fb_o      (fb_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; sample_en = 1'b0; sample_i = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mb = 0; mc = 0; md = 0; mw = 0;
    endtask

    // Drive one cycle, update model, compare all outputs
    task automatic step(input int xv, input bit e);
        sample_i  = IN_W'(xv);
        sample_en = e;
        @(negedge clk);
        if (e) begin
            mb = xv - mw;
            mc = mc + mb;
            md = (mc > 0) ? 1 : 0;
            mw = (md == 1) ? FS : -FS;
        end
        if (e) begin
            check("R2 diff", int'(diff_o), mb);
            check("R3 integ", int'(integ_o), mc);
            check("R4 bit", int'(bit_o), md);
            check("R5 fb", int'(fb_o), mw);
        end else begin
            check("R6 hold diff", int'(diff_o), mb);
            check("R6 hold integ", int'(integ_o), mc);
            check("R6 hold bit", int'(bit_o), md);
            check("R6 hold fb", int'(fb_o), mw);
        end
        n_checks++;
        if ((mc > 2*FS) || (mc < -2*FS)) begin
            n_fail++;
            $display("FAIL R10 bound: actual %0d expected within %0d", mc, 2*FS);
        end
    endtask

    initial begin
        int seed_dummy;
        int c_first;
        int sum_w;
        int exp_c [5] = '{3, -2, 9, 4, -1};
        int exp_d [5] = '{1, 0, 1, 1, 0};
        seed_dummy = $urandom(32'd20240);

        // R1: reset state
        rst = 1'b1; sample_i = IN_W'(5);
        repeat (3) @(negedge clk);
        check("R1 diff", int'(diff_o), 0);
        check("R1 integ", int'(integ_o), 0);
        check("R1 bit", int'(bit_o), 0);
        check("R1 fb", int'(fb_o), 0);
        do_reset();
        check("R1 fb after reset", int'(fb_o), 0);

        // R7 / R8: constant +3/8 trace
        sum_w = 0; c_first = 0;
        for (int n = 1; n <= 17; n++) begin
            step(3, 1'b1);
            if (n <= 5) begin
                check("R7 trace integ", int'(integ_o), exp_c[n-1]);
                check("R7 trace bit", int'(bit_o), exp_d[n-1]);
            end
            if (n == 1)  c_first = int'(integ_o);
            if (n == 8)  check("R4 zero integ gives bit 0", int'(bit_o), 0);
            if (n <= 16) sum_w += int'(fb_o);
            if (n == 17) check("R8 period 16", int'(integ_o), c_first);
        end
        check("R8 average", sum_w, 16 * 3);

        // R9 / R10: constant inputs, directed ends plus random levels
        for (int k = 0; k < 8; k++) begin
            int xc;
            int nn;
            case (k)
                0: xc = 0;
                1: xc = FS;
                2: xc = -FS;
                3: xc = 1;
                default: xc = int'($urandom_range(2*FS)) - FS;
            endcase
            nn = 20 + int'($urandom_range(12));
            do_reset();
            sum_w = 0;
            for (int n = 1; n <= nn + 1; n++) begin
                step(xc, 1'b1);
                if (n <= nn) sum_w += int'(fb_o);
            end
            check("R9 running sum", sum_w, (nn + 1) * xc - int'(integ_o));
        end

        // R2-R6: random samples with enable gaps
        do_reset();
        for (int n = 0; n < 600; n++) begin
            int xv;
            bit e;
            if (n % 97 == 5)      xv = FS;
            else if (n % 97 == 6) xv = -FS;
            else                  xv = int'($urandom_range(2*FS)) - FS;
            e = ($urandom_range(3) != 0);
            step(xv, e);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule